// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the array address for a synchronous burst memory. A burst opens when either of two active-low start strobes is seen at a rising clock edge: one belongs to the processor side, the other to the cache-controller side. Both capture the external address presented in that cycle. Later beats of the burst come from an internal beat counter. That counter steps only in cycles where the active-low advance input is low.

The upper address bits stay at the captured value for the whole burst. Only the low beat-index bits change. The order input picks one of two sequences. In linear order the low bits count upward from the start value and wrap. In interleaved order the low bits are the start value XOR the beat count. The beat counter is two bits wide by default, so one burst covers four beats before it returns to its first address. The order input is not registered. It acts on the current output at once.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `addr_out` is all zeros and `beat` is 0.
- R2: When `start_proc_n` is low at a rising edge, `addr_out` equals the `addr_in` sampled at that edge from that edge on, and `beat` reads 0.
- R3: When `start_ctrl_n` is low at a rising edge and `start_proc_n` is high, `addr_out` takes the sampled `addr_in` and `beat` reads 0.
- R4: When both strobes are low in the same cycle, exactly one load of the sampled address takes place, with `beat` 0.
- R5: When both strobes are high and `advance_n` is low at a rising edge, `beat` increases by one modulo 4.
- R6: When both strobes and `advance_n` are high at a rising edge, `addr_out` and `beat` keep their values.
- R7: With `order_il` = 0 (linear), `addr_out[1:0]` equals (captured low bits + `beat`) modulo 4.
- R8: With `order_il` = 1 (interleaved), `addr_out[1:0]` equals the captured low bits XOR `beat`.
- R9: Between loads, the bits of `addr_out` above bit 1 do not change.
- R10: After four advances the burst returns to its starting address with `beat` 0.
- R11: A strobe that arrives during a burst, even together with a low `advance_n`, restarts the burst at the new address with `beat` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_in | input | ADDR_W (21) | External start address |
| start_proc_n | input | 1 | Processor-side burst start, active low, wins on a tie |
| start_ctrl_n | input | 1 | Controller-side burst start, active low |
| advance_n | input | 1 | Beat advance, active low |
| order_il | input | 1 | 0 = linear order, 1 = interleaved order |
| addr_out | output | ADDR_W (21) | Current array address |
| beat | output | BEAT_W (2) | Beats advanced since the last load |

## Verification
The properties that relate one output address to the previous one assume that `order_il` does not change across the edge being checked. Each of those properties names this condition in its antecedent. The properties also assume the strobe and advance inputs carry known values while reset is released. The random stimulus holds the order input steady for long stretches and changes it only at intervals. Every input is driven on the falling edge, so each value is stable at the next sampling edge. Directed cases set up ties between the strobes, strobes during a burst, wrap-around in both orders and long hold stretches. The random sequence then mixes these situations with a fixed seed.

// File: rtl/burst_pkg.sv
package burst_pkg;
   typedef enum logic {
      ORD_LINEAR     = 1'b0,
      ORD_INTERLEAVE = 1'b1
   } burst_order_e;
endpackage

// File: rtl/burst_start_arb.sv
// Merges the two active-low start strobes into one load request.
// The processor strobe is tested first.
module burst_start_arb (
   input  logic start_proc_n,
   input  logic start_ctrl_n,
   output logic load
);
   always_comb begin
      if (!start_proc_n)      load = 1'b1;
      else if (!start_ctrl_n) load = 1'b1;
      else                    load = 1'b0;
   end
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
   parameter int ADDR_W = 21
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] base
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    base <= '0;
      else if (load) base <= addr_in;
   end
endmodule

// File: rtl/burst_beat_ctr.sv
// A load clears the counter and takes priority over an advance.
module burst_beat_ctr #(
   parameter int BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   output logic [BEAT_W-1:0] cnt
);
   localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (load)   cnt <= '0;
      else if (step)   cnt <= cnt + ONE;
   end
endmodule

// File: rtl/burst_beat_map.sv
// Turns the captured low bits and the beat count into the low address bits
// for either burst order.
module burst_beat_map
   import burst_pkg::*;
#(
   parameter int BEAT_W = 2
) (
   input  logic [BEAT_W-1:0] start_lo,
   input  logic [BEAT_W-1:0] cnt,
   input  burst_order_e      order,
   output logic [BEAT_W-1:0] lo
);
   logic [BEAT_W-1:0] lin_lo;
   logic [BEAT_W-1:0] il_lo;

   assign lin_lo = start_lo + cnt;

   for (genvar b = 0; b < BEAT_W; b++) begin : g_il_bit
      assign il_lo[b] = start_lo[b] ^ cnt[b];
   end

   always_comb begin
      unique case (order)
         ORD_INTERLEAVE: lo = il_lo;
         default:        lo = lin_lo;
      endcase
   end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import burst_pkg::*;
#(
   parameter int ADDR_W = 21,
   parameter int BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              start_proc_n,
   input  logic              start_ctrl_n,
   input  logic              advance_n,
   input  logic              order_il,
   output logic [ADDR_W-1:0] addr_out,
   output logic [BEAT_W-1:0] beat
);
   localparam int HI_W = ADDR_W - BEAT_W;

   if (BEAT_W < 1) begin : g_bad_beat
      $error("BEAT_W must be at least 1");
   end
   if (HI_W < 1) begin : g_bad_addr
      $error("ADDR_W must exceed BEAT_W");
   end

   logic              load;
   logic [ADDR_W-1:0] base;
   logic [BEAT_W-1:0] cnt;
   logic [BEAT_W-1:0] lo;
   burst_order_e      order;

   assign order = burst_order_e'(order_il);

   burst_start_arb u_arb (
      .start_proc_n (start_proc_n),
      .start_ctrl_n (start_ctrl_n),
      .load         (load)
   );

   burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .addr_in (addr_in),
      .base    (base)
   );

   burst_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .step  (!advance_n),
      .cnt   (cnt)
   );

   burst_beat_map #(.BEAT_W(BEAT_W)) u_map (
      .start_lo (base[BEAT_W-1:0]),
      .cnt      (cnt),
      .order    (order),
      .lo       (lo)
   );

   assign addr_out = {base[ADDR_W-1:BEAT_W], lo};
   assign beat     = cnt;
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
   parameter int ADDR_W = 21,
   parameter int BEAT_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr_in,
   input logic              start_proc_n,
   input logic              start_ctrl_n,
   input logic              advance_n,
   input logic              order_il,
   input logic [ADDR_W-1:0] addr_out,
   input logic [BEAT_W-1:0] beat
);
   localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

   logic idle;
   assign idle = start_proc_n && start_ctrl_n;

   // R1
   always_comb begin
      if (!rst_n) reset_zero_chk: assert (addr_out == '0 && beat == '0);
   end

   // R2
   proc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !start_proc_n |=> (addr_out == $past(addr_in) || $past(order_il) != order_il) && beat == '0);

   // R3
   ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_proc_n && !start_ctrl_n) |=> beat == '0);

   // R11
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle && !advance_n) |=> beat == '0);

   // R5
   advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && !advance_n) |=> beat == $past(beat) + ONE);

   // R6
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && advance_n) |=> $stable(beat) && ($stable(order_il) -> $stable(addr_out)));

   // R9
   upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idle |=> $stable(addr_out[ADDR_W-1:BEAT_W]));

   // R7
   linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && !advance_n && !order_il) |=>
         (order_il || addr_out[BEAT_W-1:0] == $past(addr_out[BEAT_W-1:0]) + ONE));

   // R8
   interleave_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && !advance_n && order_il) |=>
         (!order_il || (addr_out[BEAT_W-1:0] ^ $past(addr_out[BEAT_W-1:0])) == (beat ^ $past(beat))));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (.*);

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 21;
   localparam int BW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr_in = '0;
   logic          start_proc_n = 1'b1;
   logic          start_ctrl_n = 1'b1;
   logic          advance_n = 1'b1;
   logic          order_il = 1'b0;
   logic [AW-1:0] addr_out;
   logic [BW-1:0] beat;

   int compared = 0;
   int mismatched = 0;
   logic [AW-1:0] m_base = '0;
   logic [BW-1:0] m_cnt = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   burst_addr_gen #(.ADDR_W(AW), .BEAT_W(BW)) uut (
      .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .start_proc_n(start_proc_n),
      .start_ctrl_n(start_ctrl_n), .advance_n(advance_n), .order_il(order_il),
      .addr_out(addr_out), .beat(beat)
   );

   function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] b, logic [BW-1:0] c, logic il);
      logic [BW-1:0] lo;
      lo = il ? (b[BW-1:0] ^ c) : (b[BW-1:0] + c);
      return {b[AW-1:BW], lo};
   endfunction

   task automatic check(string tag);
      logic [AW-1:0] ea;
      ea = exp_addr(m_base, m_cnt, order_il);
      compared++;
      if (addr_out !== ea || beat !== m_cnt) begin
         mismatched++;
         $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
                  tag, addr_out, beat, ea, m_cnt);
      end
   endtask

   // Drives one cycle at the falling edge, updates the model at the rising edge,
   // then checks at the next falling edge.
   task automatic cyc(logic [AW-1:0] a, logic p_n, logic c_n, logic adv_n, logic il, string tag);
      addr_in = a; start_proc_n = p_n; start_ctrl_n = c_n; advance_n = adv_n; order_il = il;
      @(posedge clk);
      if (!p_n || !c_n) begin m_base = a; m_cnt = '0; end
      else if (!adv_n) m_cnt = m_cnt + 2'd1;
      @(negedge clk);
      check(tag);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      mismatched++;
      $display("FAIL watchdog: run did not end, actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin : stim
      int seed;
      seed = 32'h5eed_1234;
      void'($urandom(seed));
      repeat (2) @(negedge clk);
      check("R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset");

      // R2 processor load, then linear walk with wrap (R7, R10)
      cyc(21'h0ABCD2, 1'b0, 1'b1, 1'b1, 1'b0, "R2 proc load");
      for (int i = 0; i < 4; i++) cyc(21'h1FFFFF, 1'b1, 1'b1, 1'b0, 1'b0, "R7 R10 linear step");
      // R6 hold
      for (int i = 0; i < 3; i++) cyc(21'h000000, 1'b1, 1'b1, 1'b1, 1'b0, "R6 hold");
      // R3 controller load, interleaved walk (R8, R9)
      cyc(21'h123451, 1'b1, 1'b0, 1'b1, 1'b1, "R3 ctrl load");
      for (int i = 0; i < 4; i++) cyc(21'h0F0F0F, 1'b1, 1'b1, 1'b0, 1'b1, "R8 R9 interleave step");
      // R4 both strobes together
      cyc(21'h055553, 1'b0, 1'b0, 1'b1, 1'b0, "R4 both strobes");
      cyc(21'h000000, 1'b1, 1'b1, 1'b0, 1'b0, "R5 advance");
      // R11 restart mid-burst, strobe together with advance
      cyc(21'h1AAAA2, 1'b1, 1'b0, 1'b0, 1'b1, "R11 restart");
      cyc(21'h000000, 1'b1, 1'b1, 1'b0, 1'b1, "R5 advance after restart");
      cyc(21'h0CCCC1, 1'b0, 1'b1, 1'b0, 1'b1, "R11 proc restart");

      // Random mix
      for (int i = 0; i < 3000; i++) begin
         logic p_n, c_n, a_n, il;
         p_n = ($urandom % 8) != 0;
         c_n = ($urandom % 8) != 0;
         a_n = ($urandom % 3) == 0;
         il  = ((i / 200) % 2) == 1;
         cyc(AW'($urandom), p_n, c_n, a_n, il, "R5 R6 R7 R8 R11 random");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule